// File: doc/BRIEF.md
# USB OUT-Endpoint Data Toggle Checker

This block keeps the expected DATA0/DATA1 sequence bit for every OUT endpoint of a USB device controller and rules on each received data packet. When the packet-good strobe fires, the block compares the packet's data PID against that endpoint's expected bit. It then decides whether the payload is kept and reported to software, or dropped as a retransmission of a packet that was already taken. The handshake to send back is returned with the ruling.

A retransmitted packet is dropped silently but still gets a positive handshake, so that the host stops sending it again. A test-only inhibit input turns off the comparison, so every packet is accepted. The sequence bits keep advancing while it is set, so checking can resume cleanly once it is cleared. Software or the setup logic can force any endpoint back to DATA0 through a per-endpoint clear vector.

Top module: `dtog_checker`

## Requirements
- R1: After reset, every endpoint expects DATA0 and the outputs are idle: verdict_valid_o=0, accept_o=0, report_o=0, hs_o=0.
- R2: A ruling appears on the clock edge after the edge that samples pkt_valid_i=1, and it lasts exactly one cycle. In any cycle that follows an edge with pkt_valid_i=0, verdict_valid_o, accept_o and report_o are 0 and hs_o is 0 (none).
- R3: A packet whose PID bit (pkt_data1_i: 0=DATA0, 1=DATA1) equals the endpoint's expected bit gives accept_o=1 and report_o=1.
- R4: With tog_inhibit_i=0, a packet whose PID bit differs from the expected bit gives accept_o=0 and report_o=0.
- R5: Every ruled packet, whether accepted or discarded, returns a handshake. hs_o=2 (NYET) when nyet_i=1, and hs_o=1 (ACK) otherwise.
- R6: An accepted packet inverts the expected bit of its own endpoint. A discarded packet changes no expected bit, and no other endpoint's bit changes.
- R7: With tog_inhibit_i=1, every packet is accepted and reported whatever its PID, and the endpoint's expected bit is still inverted.
- R8: ep_clr_i[n]=1 sets endpoint n to DATA0 at the next edge. This overrides an inversion from a packet on endpoint n in the same cycle. That packet is still judged against the bit held before the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pkt_valid_i | input | 1 | One-cycle strobe: a good data packet has been received |
| pkt_ep_i | input | EP_W | Endpoint number of the packet |
| pkt_data1_i | input | 1 | PID type: 0=DATA0, 1=DATA1 |
| nyet_i | input | 1 | Endpoint cannot take another packet yet: answer NYET instead of ACK |
| ep_clr_i | input | NUM_EP | Per-endpoint sequence clear to DATA0 |
| tog_inhibit_i | input | 1 | Test only: accept all packets without comparing PID |
| verdict_valid_o | output | 1 | Ruling strobe |
| accept_o | output | 1 | Keep the payload |
| report_o | output | 1 | Report completion to software |
| hs_o | output | 2 | Handshake: 0 none, 1 ACK, 2 NYET |

## Verification
An endpoint's expected bit is visible only through later rulings. A corrupted bit first shows up as a wrong accept_o on the next packet to that endpoint, one cycle after its strobe. A lost or extra inversion flips every later ruling on that endpoint until a clear. The bench therefore sends long random packet runs per endpoint and compares each ruling with a model. A missed clear, or a clear that loses to a same-cycle inversion, shows up on the first packet after it.

// File: rtl/dtog_pkg.sv
package dtog_pkg;
  typedef enum logic [1:0] {
    HS_NONE = 2'd0,
    HS_ACK  = 2'd1,
    HS_NYET = 2'd2
  } hs_e;
endpackage

// File: rtl/dtog_bank.sv
module dtog_bank #(
  parameter int NUM_EP = 16,
  parameter int EP_W   = $clog2(NUM_EP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_en_i,
  input  logic [EP_W-1:0]   upd_ep_i,
  input  logic [NUM_EP-1:0] clr_i,
  output logic [NUM_EP-1:0] tog_o
);
  logic [NUM_EP-1:0] tog_q;

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    logic hit;
    assign hit = upd_en_i && (upd_ep_i == EP_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        tog_q[i] <= 1'b0;
      else if (clr_i[i])  tog_q[i] <= 1'b0;   // clear wins over flip
      else if (hit)       tog_q[i] <= ~tog_q[i];
    end

    // R6
    flip_on_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit && !clr_i[i]) |=> (tog_q[i] != $past(tog_q[i])));
    // R6
    hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!hit && !clr_i[i]) |=> $stable(tog_q[i]));
    // R8
    clear_to_data0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[i] |=> !tog_q[i]);
  end

  assign tog_o = tog_q;
endmodule

// File: rtl/dtog_judge.sv
module dtog_judge
  import dtog_pkg::*;
#(
  parameter int NUM_EP = 16,
  parameter int EP_W   = $clog2(NUM_EP)
) (
  input  logic [NUM_EP-1:0] tog_i,
  input  logic [EP_W-1:0]   ep_i,
  input  logic              data1_i,
  input  logic              nyet_i,
  input  logic              inhibit_i,
  output logic              accept_o,
  output hs_e               hs_o
);
  logic exp_bit;
  logic match;

  always_comb begin
    exp_bit  = tog_i[ep_i];
    match    = (data1_i == exp_bit);
    accept_o = inhibit_i || match;
    // duplicates still get a positive handshake
    hs_o     = nyet_i ? HS_NYET : HS_ACK;
  end
endmodule

// File: rtl/dtog_checker.sv
module dtog_checker
  import dtog_pkg::*;
#(
  parameter int NUM_EP = 16,
  localparam int EP_W  = $clog2(NUM_EP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pkt_valid_i,
  input  logic [EP_W-1:0]   pkt_ep_i,
  input  logic              pkt_data1_i,
  input  logic              nyet_i,
  input  logic [NUM_EP-1:0] ep_clr_i,
  input  logic              tog_inhibit_i,
  output logic              verdict_valid_o,
  output logic              accept_o,
  output logic              report_o,
  output logic [1:0]        hs_o
);
  logic [NUM_EP-1:0] tog_vec;
  logic              acc_w;
  hs_e               hs_w;
  logic              vld_q, acc_q;
  hs_e               hs_q;

  dtog_bank #(.NUM_EP(NUM_EP), .EP_W(EP_W)) i_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_en_i (pkt_valid_i && acc_w),
    .upd_ep_i (pkt_ep_i),
    .clr_i    (ep_clr_i),
    .tog_o    (tog_vec)
  );

  dtog_judge #(.NUM_EP(NUM_EP), .EP_W(EP_W)) i_judge (
    .tog_i     (tog_vec),
    .ep_i      (pkt_ep_i),
    .data1_i   (pkt_data1_i),
    .nyet_i    (nyet_i),
    .inhibit_i (tog_inhibit_i),
    .accept_o  (acc_w),
    .hs_o      (hs_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      acc_q <= 1'b0;
      hs_q  <= HS_NONE;
    end else begin
      vld_q <= pkt_valid_i;
      acc_q <= pkt_valid_i && acc_w;
      hs_q  <= pkt_valid_i ? hs_w : HS_NONE;
    end
  end

  assign verdict_valid_o = vld_q;
  assign accept_o        = acc_q;
  assign report_o        = acc_q;
  assign hs_o            = hs_q;

  // R2
  verdict_follows_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_i |=> verdict_valid_o);
  // R2
  idle_outputs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pkt_valid_i |=> (!verdict_valid_o && !accept_o && !report_o && hs_o == 2'd0));
  // R4
  duplicate_dropped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && !tog_inhibit_i && (pkt_data1_i != tog_vec[pkt_ep_i]))
      |=> (!accept_o && !report_o));
  // R5
  handshake_always_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_i |=> (hs_o == (($past(nyet_i)) ? 2'd2 : 2'd1)));
  // R7
  inhibit_accepts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && tog_inhibit_i) |=> (accept_o && report_o));
endmodule

// File: tb/test_dtog_checker.sv
`timescale 1ns/1ps
module test_dtog_checker;
  localparam int NUM_EP = 16;
  localparam int EP_W   = $clog2(NUM_EP);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              pkt_valid = 1'b0;
  logic [EP_W-1:0]   pkt_ep = '0;
  logic              pkt_data1 = 1'b0;
  logic              nyet = 1'b0;
  logic [NUM_EP-1:0] ep_clr = '0;
  logic              inhibit = 1'b0;
  logic              vld, acc, rep;
  logic [1:0]        hs;

  int checks = 0;
  int fails  = 0;
  logic [NUM_EP-1:0] model = '0;

  always #2.5 clk = ~clk;

  dtog_checker #(.NUM_EP(NUM_EP)) i_dtog_checker (
    .clk_i(clk), .rst_ni(rst_n), .pkt_valid_i(pkt_valid), .pkt_ep_i(pkt_ep),
    .pkt_data1_i(pkt_data1), .nyet_i(nyet), .ep_clr_i(ep_clr),
    .tog_inhibit_i(inhibit), .verdict_valid_o(vld), .accept_o(acc),
    .report_o(rep), .hs_o(hs)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_accept(logic v, logic [EP_W-1:0] e, logic d, logic inh);
    return v && (inh || (d == model[e]));
  endfunction

  function automatic logic [1:0] exp_hs(logic v, logic ny);
    return !v ? 2'd0 : (ny ? 2'd2 : 2'd1);
  endfunction

  // drive one cycle at negedge, check ruling at the following negedge
  task automatic step(logic v, logic [EP_W-1:0] e, logic d, logic ny, logic inh,
                      logic [NUM_EP-1:0] clr, string tag);
    logic ea;
    logic [1:0] eh;
    string at;
    pkt_valid = v; pkt_ep = e; pkt_data1 = d; nyet = ny; inhibit = inh; ep_clr = clr;
    ea = exp_accept(v, e, d, inh);
    eh = exp_hs(v, ny);
    if (tag != "") at = tag;
    else if (!v) at = "R2";
    else if (inh) at = "R7";
    else if (ea) at = "R3";
    else at = "R4";
    @(posedge clk);
    if (ea) model[e] = ~model[e];
    model = model & ~clr;
    @(negedge clk);
    pkt_valid = 1'b0; ep_clr = '0;
    chk("R2 valid", 32'(vld), 32'(v));
    chk({at, " accept"}, 32'(acc), 32'(ea));
    chk({at, " report"}, 32'(rep), 32'(ea));
    chk("R5 handshake", 32'(hs), 32'(eh));
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R1: idle outputs while and after reset
    chk("R1 valid", 32'(vld), 0);
    chk("R1 hs", 32'(hs), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 accept", 32'(acc), 0);
    // R1: every endpoint expects DATA0
    for (int i = 0; i < NUM_EP; i++) step(1, EP_W'(i), 0, 0, 0, '0, "R1");

    // R6: ep3 sequence; DATA0 now expected? after R1 pass all expect DATA1
    step(1, 4'd3, 1, 0, 0, '0, "R6");   // accepted, back to DATA0
    step(1, 4'd3, 1, 1, 0, '0, "R6");   // duplicate, dropped, NYET
    step(1, 4'd3, 0, 0, 0, '0, "R6");   // accepted
    step(1, 4'd4, 0, 0, 0, '0, "R6");   // ep4 untouched: still DATA1 -> drop
    step(0, 4'd3, 0, 0, 0, '0, "R2");

    // R7: inhibit accepts mismatch and still flips
    step(1, 4'd5, 0, 0, 1, '0, "R7");   // ep5 expects DATA1, accepted anyway
    step(1, 4'd5, 1, 0, 0, '0, "R7");   // now expects DATA0 -> drop
    step(1, 4'd5, 0, 0, 0, '0, "R7");

    // R8: clear, and clear with same-cycle packet
    step(0, 4'd0, 0, 0, 0, NUM_EP'(1) << 6, "R8");
    step(1, 4'd6, 0, 0, 0, '0, "R8");   // DATA0 accepted after clear
    step(1, 4'd7, 1, 0, 0, NUM_EP'(1) << 7, "R8"); // judged pre-clear: ep7 DATA1
    step(1, 4'd7, 0, 0, 0, '0, "R8");   // clear won: DATA0 accepted
    step(1, 4'd7, 0, 0, 0, '0, "R8");   // now duplicate

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [EP_W-1:0] e;
      logic v, d, ny, inh;
      logic [NUM_EP-1:0] clr;
      e   = EP_W'($urandom % NUM_EP);
      v   = ($urandom % 10) < 7;
      d   = (($urandom % 4) == 0) ? ~model[e] : (($urandom % 2) == 0 ? model[e] : ~model[e]);
      ny  = ($urandom % 3) == 0;
      inh = ($urandom % 12) == 0;
      clr = (($urandom % 16) == 0) ? (NUM_EP'(1) << ($urandom % NUM_EP)) : '0;
      step(v, e, d, ny, inh, clr, "");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule